// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a simple synchronous request bus and an asynchronous static RAM with a 16-bit shared data bus. A requester presents an address, write data, a two-bit lane mask and a read/write flag with a valid strobe. The controller converts that request into a timed sequence on the RAM's active-low chip enable, write enable, output enable and the two byte-lane enables. When the access is done it returns a one-clock ready pulse, and for reads a registered data word.

Every phase length is a clock-count parameter: address setup, write strobe width, data hold after the strobe, and read access time. The RAM data pins are split into an output word, an input word and a drive-enable, so a pad ring or an FPGA top level can build the tri-state buffer. The controller releases its drivers before the RAM is allowed to drive. It raises write enable before chip enable and the byte enables. It changes the address only while chip enable is high.

The requester must hold valid and its payload stable until it sees ready. A request is accepted on a clock edge where the controller is idle and ready is low.

Top module: `sram_ctl`

## Requirements
- R1: After reset, chip enable, write enable, output enable and both byte enables are high (inactive), the data drive-enable is low, ready is low and the read data word is zero.
- R2: A write with a nonzero mask holds chip enable low with write enable high for T_SETUP cycles. It then holds write enable low for T_PULSE cycles, then write enable high with chip enable still low for T_HOLD cycles. Ready rises T_SETUP+T_PULSE+T_HOLD+1 cycles after the request is presented to an idle controller, and the addressed RAM word holds the merged data.
- R3: Write enable is low only while chip enable is low. It never falls in the first cycle of chip enable being low, and it is high again before chip enable rises.
- R4: The memory address equals the accepted request address whenever chip enable is low, and it changes only while chip enable is high.
- R5: Mask bit 0 selects the lower lane (data bits 7:0, lower byte enable) and mask bit 1 selects the upper lane (bits 15:8, upper byte enable). During an access each byte enable is low exactly when its mask bit is 1. When chip enable is high, both byte enables are high.
- R6: During every cycle of a write in which chip enable is low, the data drive-enable is high, output enable is high and the output word equals the request's write data. In no other cycle is the drive-enable high.
- R7: A read with a nonzero mask holds chip enable and output enable low, with write enable high, for T_ACCESS cycles. Ready rises T_ACCESS+1 cycles after the request is presented to an idle controller.
- R8: The read data word is registered from the RAM input at the end of the last access cycle. Enabled lanes carry RAM data and disabled lanes read as zero. The word is held unchanged until the next read with a nonzero mask completes.
- R9: The data drive-enable and a low output enable are never active in the same cycle, and the drive-enable is low in the cycle before output enable falls.
- R10: A request with an all-zero mask produces ready one cycle after it is presented. It asserts no chip enable, write enable or output enable, and leaves RAM contents and the read data word unchanged.
- R11: Ready is high for exactly one cycle per transaction. A request is not accepted in a cycle where ready is high, and chip enable is high in the cycle after ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for the data pads |
| mem_dq_in | input | 16 | Data received from the RAM pads |

## Verification
The assertions check the pin rules on every clock:
- write enable is nested inside chip enable and falls after it and rises before it;
- the address stays stable across a chip-enable-low window;
- the drive-enable and output enable never overlap, with a turnaround cycle;
- ready lasts one cycle;
- the read word holds between captures.

Only the bench's scenarios show the rest: exact phase lengths, lane merging into RAM, zero filling of disabled read lanes, and zero-mask requests leaving RAM and read data untouched. The bench shows these by comparing a RAM model driven by the pins with a reference array kept from the requests.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_HOLD,
        PH_RD_ACCESS
    } phase_e;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             drive;
    } strobe_t;

    function automatic int unsigned widest(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic strobe_t decode_phase(input phase_e ph, input logic [LANES-1:0] lanes);
        strobe_t s;
        logic active;
        active   = (ph != PH_IDLE);
        s.ce_n   = !active;
        s.we_n   = (ph != PH_WR_PULSE);
        s.oe_n   = (ph != PH_RD_ACCESS);
        s.lane_n = active ? ~lanes : {LANES{1'b1}};
        s.drive  = (ph == PH_WR_SETUP) || (ph == PH_WR_PULSE) || (ph == PH_WR_HOLD);
        return s;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R2: once loaded, the phase timer never wraps while counting down
    a_r2_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int T_SETUP  = 1,
    parameter int T_PULSE  = 2,
    parameter int T_HOLD   = 1,
    parameter int T_ACCESS = 3,
    parameter int CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    input  logic             timer_done,
    output phase_e           phase,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             take,
    output logic             capture,
    output logic             ready
);

    localparam logic [CNT_W-1:0] LV_SETUP  = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] LV_PULSE  = CNT_W'(T_PULSE - 1);
    localparam logic [CNT_W-1:0] LV_HOLD   = CNT_W'(T_HOLD - 1);
    localparam logic [CNT_W-1:0] LV_ACCESS = CNT_W'(T_ACCESS - 1);

    phase_e nxt;
    logic   finish;
    logic   accept;

    assign accept = (phase == PH_IDLE) && req_valid && !ready;

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        take     = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (accept) begin
                    if (req_mask == '0) begin
                        finish = 1'b1;
                    end else if (req_write) begin
                        take     = 1'b1;
                        nxt      = PH_WR_SETUP;
                        load     = 1'b1;
                        load_val = LV_SETUP;
                    end else begin
                        take     = 1'b1;
                        nxt      = PH_RD_ACCESS;
                        load     = 1'b1;
                        load_val = LV_ACCESS;
                    end
                end
            end
            PH_WR_SETUP: if (timer_done) begin
                nxt      = PH_WR_PULSE;
                load     = 1'b1;
                load_val = LV_PULSE;
            end
            PH_WR_PULSE: if (timer_done) begin
                nxt      = PH_WR_HOLD;
                load     = 1'b1;
                load_val = LV_HOLD;
            end
            PH_WR_HOLD: if (timer_done) begin
                nxt    = PH_IDLE;
                finish = 1'b1;
            end
            PH_RD_ACCESS: if (timer_done) begin
                nxt     = PH_IDLE;
                finish  = 1'b1;
                capture = 1'b1;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ready <= 1'b0;
        end else begin
            phase <= nxt;
            ready <= finish;
        end
    end

    // R11: completion pulse lasts a single cycle
    a_r11_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R11: nothing is started while the completion pulse is high
    a_r11_no_take_on_ready: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && ready) |=> (phase == PH_IDLE));

    // R2: the write strobe phase is only reached from the setup phase
    a_r2_pulse_after_setup: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR_PULSE && $past(phase) != PH_WR_PULSE) |-> ($past(phase) == PH_WR_SETUP));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_mask,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    output logic [LANES-1:0]  lanes_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    strobe_t           strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            lanes_q <= req_mask;
        end
    end

    assign strb       = decode_phase(phase, lanes_q);
    assign mem_addr   = addr_q;
    assign mem_ce_n   = strb.ce_n;
    assign mem_we_n   = strb.we_n;
    assign mem_oe_n   = strb.oe_n;
    assign mem_lb_n   = strb.lane_n[0];
    assign mem_ub_n   = strb.lane_n[1];
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = strb.drive;

    // R3: write strobe nested inside chip enable
    a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_ce_n);

    // R3: write strobe falls only after chip enable was already low
    a_r3_we_falls_last: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !$past(mem_ce_n));

    // R3: write strobe released before chip enable rises
    a_r3_we_rises_first: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(mem_we_n));

    // R4: address frozen across a chip-enable-low window
    a_r4_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R9: pad drivers and RAM outputs never both on
    a_r9_no_clash: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    // R9: a turnaround cycle precedes output enable
    a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  lanes,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[g*LANE_W +: LANE_W] <= '0;
            else if (capture)
                rdata[g*LANE_W +: LANE_W] <= lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
    end

    // R8: read word held between captures
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rdata));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int T_SETUP  = 1,
    parameter int T_PULSE  = 2,
    parameter int T_HOLD   = 1,
    parameter int T_ACCESS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_ready,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [15:0]       mem_dq_in
);

    localparam int unsigned LONGEST = widest(T_SETUP, T_PULSE, T_HOLD, T_ACCESS);
    localparam int CNT_W = $clog2(LONGEST + 1);

    phase_e           phase;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             timer_done;
    logic             take;
    logic             capture;
    logic [LANES-1:0] lanes_q;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (timer_done)
    );

    sram_ctl_seq #(
        .T_SETUP  (T_SETUP),
        .T_PULSE  (T_PULSE),
        .T_HOLD   (T_HOLD),
        .T_ACCESS (T_ACCESS),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_mask   (req_mask),
        .timer_done (timer_done),
        .phase      (phase),
        .load       (load),
        .load_val   (load_val),
        .take       (take),
        .capture    (capture),
        .ready      (rsp_ready)
    );

    sram_ctl_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .req_addr   (req_addr),
        .req_mask   (req_mask),
        .req_wdata  (req_wdata),
        .phase      (phase),
        .lanes_q    (lanes_q),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_ctl_rdcap u_rdcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .lanes   (lanes_q),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata)
    );

    // R10: a zero-mask request leaves every strobe idle
    a_r10_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && req_valid && !rsp_ready && req_mask == 2'b00)
            |=> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TS = 2;
    localparam int TP = 3;
    localparam int TH = 1;
    localparam int TA = 4;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_ready;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0]   mem_dq_out;
    logic          mem_dq_oe;
    logic [15:0]   mem_dq_in;

    int checks = 0;
    int fails  = 0;

    logic [15:0] ram     [256];
    logic [15:0] ref_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_ACCESS(TA)
    ) u_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // RAM model: writes land on the rising edge of the write strobe
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            if (mem_lb_n === 1'b0) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (mem_ub_n === 1'b0) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    // undriven lanes float; modelled as a fixed junk pattern
    assign mem_dq_in = (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) ?
        { (mem_ub_n ? 8'h5A : ram[mem_addr[7:0]][15:8]),
          (mem_lb_n ? 8'h5A : ram[mem_addr[7:0]][7:0]) } : 16'hA55A;

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        return { (m[1] ? d[15:8] : old[15:8]), (m[0] ? d[7:0] : old[7:0]) };
    endfunction

    function automatic logic [15:0] read_expect(input logic [15:0] w, input logic [1:0] m);
        return { (m[1] ? w[15:8] : 8'h00), (m[0] ? w[7:0] : 8'h00) };
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // present one request at a negedge with ready low; return at a negedge with ready low
    task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        int cnt = 0;
        int ce_lo = 0, we_lo = 0, oe_lo = 0, drv = 0;
        int addr_err = 0, lane_err = 0, data_err = 0, clash = 0, edge_err = 0;
        int total;
        logic [15:0] prev_rd;
        total = (m == 2'b00) ? 0 : (wr ? TS + TP + TH : TA);
        prev_rd   = rsp_rdata;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        do begin
            @(negedge clk);
            cnt++;
            if (!mem_ce_n) begin
                ce_lo++;
                if (mem_addr != a) addr_err++;
                if ({mem_ub_n, mem_lb_n} != ~m) lane_err++;
                if (wr && (mem_dq_out != d || !mem_dq_oe || !mem_oe_n)) data_err++;
            end else if ({mem_ub_n, mem_lb_n} != 2'b11) lane_err++;
            if (!mem_we_n) we_lo++;
            if (!mem_oe_n) oe_lo++;
            if (mem_dq_oe) drv++;
            if (mem_dq_oe && !mem_oe_n) clash++;
            if (!mem_we_n && mem_ce_n) edge_err++;
            if (total != 0 && (cnt == 1 || cnt == total) && !mem_we_n) edge_err++;
        end while (!rsp_ready && cnt < 100);
        req_valid = 1'b0;

        if (wr) check(cnt == total + 1, "R2", "write latency", cnt, total + 1);
        else if (m != 0) check(cnt == total + 1, "R7", "read latency", cnt, total + 1);
        if (m == 2'b00) begin
            check(cnt == 1, "R10", "zero-mask latency", cnt, 1);
            check(ce_lo == 0 && we_lo == 0 && oe_lo == 0, "R10", "zero-mask strobes",
                  ce_lo + we_lo + oe_lo, 0);
        end
        check(ce_lo == total, "R2", "chip enable low cycles", ce_lo, total);
        check(we_lo == ((wr && m != 0) ? TP : 0), "R2", "write strobe cycles", we_lo,
              (wr && m != 0) ? TP : 0);
        check(edge_err == 0, "R3", "strobe ordering", edge_err, 0);
        check(addr_err == 0, "R4", "address during access", addr_err, 0);
        check(lane_err == 0, "R5", "byte enables", lane_err, 0);
        check(data_err == 0, "R6", "write data on pads", data_err, 0);
        check(drv == ((wr && m != 0) ? total : 0), "R6", "drive cycles", drv,
              (wr && m != 0) ? total : 0);
        check(oe_lo == ((!wr && m != 0) ? TA : 0), "R7", "output enable cycles", oe_lo,
              (!wr && m != 0) ? TA : 0);
        check(clash == 0, "R9", "drive overlap", clash, 0);

        if (wr && m != 0) begin
            ref_mem[a[7:0]] = merge(ref_mem[a[7:0]], d, m);
            check(ram[a[7:0]] == ref_mem[a[7:0]], "R2", "RAM word after write",
                  ram[a[7:0]], ref_mem[a[7:0]]);
        end
        if (wr || m == 2'b00)
            check(rsp_rdata == prev_rd, (m == 2'b00) ? "R10" : "R8", "read word unchanged",
                  rsp_rdata, prev_rd);
        else
            check(rsp_rdata == read_expect(ref_mem[a[7:0]], m), "R8", "read data",
                  rsp_rdata, read_expect(ref_mem[a[7:0]], m));
        if (m == 2'b00)
            check(ram[a[7:0]] == ref_mem[a[7:0]], "R10", "RAM untouched",
                  ram[a[7:0]], ref_mem[a[7:0]]);

        @(negedge clk);
        check(!rsp_ready, "R11", "ready single cycle", rsp_ready, 0);
        check(mem_ce_n, "R11", "standby after ready", mem_ce_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]     = 16'(i * 16'h0101 ^ 16'h3C00);
            ref_mem[i] = 16'(i * 16'h0101 ^ 16'h3C00);
        end
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1",
              "strobes after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
        check(!mem_dq_oe && !rsp_ready, "R1", "drive and ready after reset",
              {mem_dq_oe, rsp_ready}, 0);
        check(rsp_rdata == 16'h0, "R1", "read word after reset", rsp_rdata, 0);

        // directed corners
        run_op(1'b1, 18'h2A010, 16'hBEEF, 2'b11);
        run_op(1'b0, 18'h2A010, 16'h0000, 2'b11);
        run_op(1'b1, 18'h00010, 16'h1234, 2'b01);
        run_op(1'b0, 18'h00010, 16'h0000, 2'b11);
        run_op(1'b1, 18'h3FF10, 16'h9A00, 2'b10);
        run_op(1'b0, 18'h3FF10, 16'h0000, 2'b01);
        run_op(1'b0, 18'h3FF10, 16'h0000, 2'b10);
        run_op(1'b1, 18'h00010, 16'hFFFF, 2'b00);
        run_op(1'b0, 18'h00011, 16'h0000, 2'b00);
        run_op(1'b0, 18'h00010, 16'h0000, 2'b11);
        run_op(1'b1, 18'h00020, 16'h1111, 2'b11);
        run_op(1'b1, 18'h3FF21, 16'h2222, 2'b11);
        run_op(1'b0, 18'h00021, 16'h0000, 2'b11);

        // constrained random mix
        for (int n = 0; n < 120; n++) begin
            logic [AW-1:0] a;
            logic [1:0]    m;
            a = {10'($urandom()), 4'h0, 4'($urandom())};
            m = ($urandom() % 8 == 0) ? 2'b00 : 2'($urandom() % 3 + 1);
            run_op(1'($urandom()), a, 16'($urandom()), m);
        end
        summary();
    end

endmodule